// File: doc/BRIEF.md
# Event-Register Interrupt Controller

This block collects a parameterised number of level-sensitive interrupt lines (a multiple of 32) and gives each core of a small multi-core cluster one interrupt request output. Software reaches it through a flat 32-bit register space with separate read and write strobes and a core-identifier input that tells the block which core performs each access. Each line can be made pending by its input pin or by a software-pending bit. Each line has a mask bit and a per-core routing set. Software-pending and mask bits are only changed through paired write-one-to-set and write-one-to-clear addresses.

A core learns what to service by reading a single event word. The word packs an event kind in its upper half and a line number or inter-processor code in its lower half. Reading a line event masks that line as a side effect, and reading an inter-processor event masks that core's inter-processor source. A service loop therefore reads the event word until it returns zero, handles each event, and then writes the matching unmask. Any core may raise an inter-processor interrupt on any set of cores with one write.

Top module: `evtirq_ctrl`

## Requirements
- R1: A read of address 0x0004 returns the number of lines (NUM_LINES) in bits 15:0 and zero above.
- R2: A read of address 0x2000 returns the value on the core-identifier input of that access.
- R3: After reset every line is masked, no software-pending bit is set, every routing set is empty, no inter-processor interrupt is pending or masked, all core outputs are low and every event read returns zero.
- R4: Software-pending bits are written one-to-set at 0x4000 + 4·(n/32) and one-to-clear at 0x4080 + 4·(n/32), at bit n mod 32. A read of either address returns the current bits of that word.
- R5: Mask bits are written one-to-set at 0x4100 + 4·(n/32) and one-to-clear at 0x4180 + 4·(n/32), at bit n mod 32. A read of either address returns the current mask word.
- R6: A line is pending when its input is high or its software-pending bit is set. An event read at 0x2004 by core c returns kind 1 in bits 31:16 and the line number in bits 15:0 for the lowest-numbered pending line that is unmasked and whose routing set holds c.
- R7: An event read that returns a line sets that line's mask bit, so the line is not returned again until its mask is cleared.
- R8: A write to 0x2008 makes an inter-processor interrupt pending on every core whose bit is set in the written data. While a core's interrupt is pending and unmasked, its event read returns kind 4 with data 1, ahead of any line.
- R9: An event read that returns kind 4 masks that core's inter-processor interrupt. Writing bit 0 at 0x2028 unmasks it for the writing core, and writing bit 0 at 0x200C clears its pending state.
- R10: Core output c is high exactly when an event read by core c would return a non-zero word, and it follows the inputs in the same cycle.
- R11: The routing set of line n is at 0x3000 + 4·n. Bit c selects core c. Bits at and above NUM_CORES are dropped and read back as zero.
- R12: When no routed event is eligible, an event read returns zero (kind 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_core | input | CORE_W | Index of the core making the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe; wins over a read in the same cycle |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_in | input | NUM_LINES | Level-sensitive interrupt lines |
| core_irq | output | NUM_CORES | Interrupt request per core |

## Verification
Read data is combinational, so each read is checked a few nanoseconds after the strobe is driven on the falling edge, well before the rising edge that takes its side effects. Writes and the automatic masking of an event read take effect at that rising edge. The bench applies them to its model at the edge, so the next access sees them. Core outputs follow the line inputs and the stored state with no register delay, so they are compared against the model at the mid-cycle sample point of every access.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;

  localparam logic [15:0] A_INFO       = 16'h0004;
  localparam logic [15:0] A_WHOAMI     = 16'h2000;
  localparam logic [15:0] A_EVENT      = 16'h2004;
  localparam logic [15:0] A_IPI_SEND   = 16'h2008;
  localparam logic [15:0] A_IPI_ACK    = 16'h200C;
  localparam logic [15:0] A_IPI_UNMASK = 16'h2028;

  localparam logic [3:0]  A_ROUTE_PAGE = 4'h3;
  localparam logic [6:0]  A_BANK_PAGE  = 7'b0100_000;

  typedef enum logic [15:0] {
    EV_NONE = 16'd0,
    EV_LINE = 16'd1,
    EV_IPI  = 16'd4
  } ev_kind_t;

  localparam logic [15:0] IPI_FROM_PEER = 16'd1;

endpackage

// File: rtl/evtirq_linebank.sv
module evtirq_linebank #(
  parameter int NUM_LINES = 64,
  parameter int NUM_CORES = 4,
  localparam int WORDS  = NUM_LINES / 32,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  swp_set_we,
  input  logic                                  swp_clr_we,
  input  logic                                  msk_set_we,
  input  logic                                  msk_clr_we,
  input  logic [WORD_W-1:0]                     word_sel,
  input  logic [31:0]                           wdata,
  input  logic                                  route_we,
  input  logic [LINE_W-1:0]                     route_sel,
  input  logic [NUM_CORES-1:0]                  route_wdata,
  input  logic                                  claim_we,
  input  logic [LINE_W-1:0]                     claim_sel,
  output logic [NUM_LINES-1:0]                  swp_o,
  output logic [NUM_LINES-1:0]                  mask_o,
  output logic [NUM_LINES-1:0][NUM_CORES-1:0]   route_o
);

  logic [NUM_LINES-1:0] swp_q, swp_d;
  logic [NUM_LINES-1:0] mask_q, mask_d;
  logic                 bank_en;

  always_comb begin
    swp_d  = swp_q;
    mask_d = mask_q;
    for (int w = 0; w < WORDS; w++) begin
      if (int'(word_sel) == w) begin
        if (swp_set_we) swp_d[w*32 +: 32]  = swp_q[w*32 +: 32] | wdata;
        if (swp_clr_we) swp_d[w*32 +: 32]  = swp_q[w*32 +: 32] & ~wdata;
        if (msk_set_we) mask_d[w*32 +: 32] = mask_q[w*32 +: 32] | wdata;
        if (msk_clr_we) mask_d[w*32 +: 32] = mask_q[w*32 +: 32] & ~wdata;
      end
    end
    if (claim_we) mask_d[claim_sel] = 1'b1;
  end

  assign bank_en = swp_set_we | swp_clr_we | msk_set_we | msk_clr_we | claim_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swp_q  <= '0;
      mask_q <= '1;
    end else if (bank_en) begin
      swp_q  <= swp_d;
      mask_q <= mask_d;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_route
    logic [NUM_CORES-1:0] route_q;
    logic                 route_en;

    assign route_en = route_we && (route_sel == LINE_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        route_q <= '0;
      else if (route_en) route_q <= route_wdata;
    end

    assign route_o[i] = route_q;
  end

  assign swp_o  = swp_q;
  assign mask_o = mask_q;

  // R7: a claimed line is masked from the next cycle
  p_claim_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    claim_we |=> mask_q[$past(claim_sel)]);

  for (genvar w = 0; w < WORDS; w++) begin : g_word_chk
    // R5: one-to-clear removes every written bit
    p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_clr_we && int'(word_sel) == w) |=>
        ((mask_q[w*32 +: 32] & $past(wdata)) == 32'd0));
    // R4: one-to-set raises every written bit
    p_swp_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (swp_set_we && int'(word_sel) == w) |=>
        ((swp_q[w*32 +: 32] & $past(wdata)) == $past(wdata)));
  end

endmodule

// File: rtl/evtirq_picker.sv
module evtirq_picker #(
  parameter int NUM_LINES = 64,
  parameter int NUM_CORES = 4,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]                  irq_in,
  input  logic [NUM_LINES-1:0]                  swp,
  input  logic [NUM_LINES-1:0]                  mask,
  input  logic [NUM_LINES-1:0][NUM_CORES-1:0]   route,
  output logic [NUM_CORES-1:0]                  hit_o,
  output logic [NUM_CORES-1:0][LINE_W-1:0]      idx_o
);

  logic [NUM_LINES-1:0] live;

  assign live = (irq_in | swp) & ~mask;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic              hit_c;
    logic [LINE_W-1:0] idx_c;

    // scan from the top so the lowest eligible line is written last
    always_comb begin
      hit_c = 1'b0;
      idx_c = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
        if (live[i] && route[i][c]) begin
          hit_c = 1'b1;
          idx_c = LINE_W'(i);
        end
      end
    end

    assign hit_o[c] = hit_c;
    assign idx_o[c] = idx_c;
  end

endmodule

// File: rtl/evtirq_ipi.sv
module evtirq_ipi #(
  parameter int NUM_CORES = 4,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CORE_W-1:0]    core_sel,
  input  logic                 send_we,
  input  logic                 ack_we,
  input  logic                 unmask_we,
  input  logic                 claim_we,
  input  logic [31:0]          wdata,
  output logic [NUM_CORES-1:0] pend_o,
  output logic [NUM_CORES-1:0] mask_o
);

  logic [NUM_CORES-1:0] pend_q, pend_d;
  logic [NUM_CORES-1:0] mask_q, mask_d;
  logic                 ipi_en;

  always_comb begin
    pend_d = pend_q;
    mask_d = mask_q;
    if (send_we)               pend_d = pend_q | wdata[NUM_CORES-1:0];
    if (ack_we && wdata[0])    pend_d[core_sel] = 1'b0;
    if (unmask_we && wdata[0]) mask_d[core_sel] = 1'b0;
    if (claim_we)              mask_d[core_sel] = 1'b1;
  end

  assign ipi_en = send_we | ack_we | unmask_we | claim_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else if (ipi_en) begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  // R8: every addressed core becomes pending
  p_ipi_send_r8: assert property (@(posedge clk) disable iff (!rst_n)
    send_we |=> ((pend_q & $past(wdata[NUM_CORES-1:0])) == $past(wdata[NUM_CORES-1:0])));
  // R9: acknowledge drops the writer's pending state
  p_ipi_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && wdata[0]) |=> !pend_q[$past(core_sel)]);
  // R9: claiming the event masks the reader's source
  p_ipi_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    claim_we |=> mask_q[$past(core_sel)]);

endmodule

// File: rtl/evtirq_ctrl.sv
module evtirq_ctrl
  import evtirq_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CORES = 4,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CORE_W-1:0]    bus_core,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [15:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_CORES-1:0] core_irq
);

  localparam int WORDS  = NUM_LINES / 32;
  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // address decode
  logic              rd_go, core_ok;
  logic              is_info, is_whoami, is_event, is_send, is_ack, is_unmask;
  logic              is_route, is_bank, bank_msk, bank_clr;
  logic [LINE_W-1:0] route_idx;
  logic [WORD_W-1:0] bank_word;

  always_comb begin
    rd_go     = bus_rd & ~bus_wr;
    core_ok   = int'(bus_core) < NUM_CORES;
    is_info   = bus_addr == A_INFO;
    is_whoami = bus_addr == A_WHOAMI;
    is_event  = bus_addr == A_EVENT;
    is_send   = bus_addr == A_IPI_SEND;
    is_ack    = bus_addr == A_IPI_ACK;
    is_unmask = bus_addr == A_IPI_UNMASK;
    is_route  = (bus_addr[15:12] == A_ROUTE_PAGE) && (bus_addr[1:0] == 2'b00) &&
                (int'(bus_addr[11:2]) < NUM_LINES);
    is_bank   = (bus_addr[15:9] == A_BANK_PAGE) && (bus_addr[1:0] == 2'b00) &&
                (int'(bus_addr[6:2]) < WORDS);
    bank_msk  = bus_addr[8];
    bank_clr  = bus_addr[7];
    route_idx = bus_addr[LINE_W+1:2];
    bank_word = bus_addr[WORD_W+1:2];
  end

  // state blocks
  logic [NUM_LINES-1:0]                swp_v, mask_v;
  logic [NUM_LINES-1:0][NUM_CORES-1:0] route_v;
  logic [NUM_CORES-1:0]                hit;
  logic [NUM_CORES-1:0][LINE_W-1:0]    idx;
  logic [NUM_CORES-1:0]                ipi_pend, ipi_mask, ipi_rdy;
  logic                                ev_rd, ipi_claim, line_claim;
  logic [LINE_W-1:0]                   claim_idx;

  evtirq_linebank #(
    .NUM_LINES (NUM_LINES),
    .NUM_CORES (NUM_CORES)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .swp_set_we  (bus_wr & is_bank & ~bank_msk & ~bank_clr),
    .swp_clr_we  (bus_wr & is_bank & ~bank_msk &  bank_clr),
    .msk_set_we  (bus_wr & is_bank &  bank_msk & ~bank_clr),
    .msk_clr_we  (bus_wr & is_bank &  bank_msk &  bank_clr),
    .word_sel    (bank_word),
    .wdata       (bus_wdata),
    .route_we    (bus_wr & is_route),
    .route_sel   (route_idx),
    .route_wdata (bus_wdata[NUM_CORES-1:0]),
    .claim_we    (line_claim),
    .claim_sel   (claim_idx),
    .swp_o       (swp_v),
    .mask_o      (mask_v),
    .route_o     (route_v)
  );

  evtirq_picker #(
    .NUM_LINES (NUM_LINES),
    .NUM_CORES (NUM_CORES)
  ) u_pick (
    .irq_in (irq_in),
    .swp    (swp_v),
    .mask   (mask_v),
    .route  (route_v),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  evtirq_ipi #(
    .NUM_CORES (NUM_CORES)
  ) u_ipi (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .core_sel  (bus_core),
    .send_we   (bus_wr & is_send),
    .ack_we    (bus_wr & is_ack & core_ok),
    .unmask_we (bus_wr & is_unmask & core_ok),
    .claim_we  (ipi_claim),
    .wdata     (bus_wdata),
    .pend_o    (ipi_pend),
    .mask_o    (ipi_mask)
  );

  assign ipi_rdy = ipi_pend & ~ipi_mask;

  // per-core event word; inter-processor events win over lines
  logic [NUM_CORES-1:0][31:0] ev_word;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      if (ipi_rdy[c])  ev_word[c] = {EV_IPI, IPI_FROM_PEER};
      else if (hit[c]) ev_word[c] = {EV_LINE, 16'(idx[c])};
      else             ev_word[c] = {EV_NONE, 16'd0};
    end
  end

  assign core_irq = ipi_rdy | hit;

  // claim side effects of an event read
  always_comb begin
    ev_rd      = rd_go & is_event & core_ok;
    ipi_claim  = ev_rd & ipi_rdy[bus_core];
    line_claim = ev_rd & ~ipi_rdy[bus_core] & hit[bus_core];
    claim_idx  = idx[bus_core];
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (is_info)                   bus_rdata = 32'(NUM_LINES);
    else if (is_whoami)            bus_rdata = 32'(bus_core);
    else if (is_event && core_ok)  bus_rdata = ev_word[bus_core];
    else if (is_route)             bus_rdata = 32'(route_v[route_idx]);
    else if (is_bank && bank_msk)  bus_rdata = mask_v[int'(bank_word)*32 +: 32];
    else if (is_bank)              bus_rdata = swp_v[int'(bank_word)*32 +: 32];
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
    // R7: a line returned to a core is not returned to it again next cycle
    p_no_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
      (line_claim && bus_core == CORE_W'(c)) |=> !(hit[c] && idx[c] == $past(claim_idx)));
    // R6: the line offered to a core is unmasked in the bank
    p_offer_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
      hit[c] |-> !mask_v[idx[c]]);
  end

endmodule

// File: tb/evtirq_ctrl_tb.sv
module evtirq_ctrl_tb;

  localparam int N = 64;
  localparam int C = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_core;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [N-1:0] irq_in;
  logic [C-1:0] core_irq;

  always #10 clk = ~clk;

  evtirq_ctrl #(.NUM_LINES(N), .NUM_CORES(C)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_core(bus_core), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .core_irq(core_irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [N-1:0] m_sw, m_mask, m_lines;
  logic [C-1:0] m_aff [N];
  logic [C-1:0] m_ipip, m_ipim;

  function automatic logic [31:0] exp_event(int c);
    if (m_ipip[c] && !m_ipim[c]) return 32'h0004_0001;
    for (int i = 0; i < N; i++)
      if ((m_lines[i] || m_sw[i]) && !m_mask[i] && m_aff[i][c]) return {16'd1, 16'(i)};
    return 32'd0;
  endfunction

  function automatic logic [31:0] exp_read(int c, logic [15:0] a);
    int w;
    if (a == 16'h0004) return 32'(N);
    if (a == 16'h2000) return 32'(c);
    if (a == 16'h2004) return exp_event(c);
    if (a[15:12] == 4'h3 && a[1:0] == 2'b00 && int'(a[11:2]) < N) return 32'(m_aff[a[11:2]]);
    if (a[1:0] == 2'b00 && int'(a[6:2]) < N/32) begin
      w = int'(a[6:2]);
      case (a[15:7])
        9'h080, 9'h081: return m_sw[w*32 +: 32];
        9'h082, 9'h083: return m_mask[w*32 +: 32];
        default: ;
      endcase
    end
    return 32'd0;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(int c, bit wr, bit rd, logic [15:0] a, logic [31:0] d,
                    string tag, output logic [31:0] q);
    logic [31:0] ev;
    logic [C-1:0] eirq;
    int w;
    @(negedge clk);
    bus_core = 2'(c); bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #5;
    for (int k = 0; k < C; k++) eirq[k] = exp_event(k) != 0;
    check("R10", 32'(core_irq), 32'(eirq));
    q = bus_rdata;
    if (rd && !wr) check(tag, bus_rdata, exp_read(c, a));
    ev = exp_event(c);
    @(posedge clk);
    if (wr) begin
      if (a == 16'h2008) m_ipip = m_ipip | d[C-1:0];
      if (a == 16'h200C && d[0]) m_ipip[c] = 1'b0;
      if (a == 16'h2028 && d[0]) m_ipim[c] = 1'b0;
      if (a[15:12] == 4'h3 && a[1:0] == 2'b00 && int'(a[11:2]) < N) m_aff[a[11:2]] = d[C-1:0];
      if (a[1:0] == 2'b00 && int'(a[6:2]) < N/32) begin
        w = int'(a[6:2]);
        case (a[15:7])
          9'h080: m_sw[w*32 +: 32]   = m_sw[w*32 +: 32] | d;
          9'h081: m_sw[w*32 +: 32]   = m_sw[w*32 +: 32] & ~d;
          9'h082: m_mask[w*32 +: 32] = m_mask[w*32 +: 32] | d;
          9'h083: m_mask[w*32 +: 32] = m_mask[w*32 +: 32] & ~d;
          default: ;
        endcase
      end
    end else if (rd && a == 16'h2004) begin
      if (ev[31:16] == 16'd4)      m_ipim[c] = 1'b1;
      else if (ev[31:16] == 16'd1) m_mask[int'(ev[15:0])] = 1'b1;
    end
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rd(int c, logic [15:0] a, string tag, output logic [31:0] q);
    op(c, 1'b0, 1'b1, a, 32'd0, tag, q);
  endtask

  task automatic wr(int c, logic [15:0] a, logic [31:0] d);
    logic [31:0] q;
    op(c, 1'b1, 1'b0, a, d, "write", q);
  endtask

  task automatic set_lines(logic [N-1:0] v);
    logic [C-1:0] eirq;
    @(negedge clk);
    irq_in = v; m_lines = v;
    #5;
    for (int k = 0; k < C; k++) eirq[k] = exp_event(k) != 0;
    check("R10", 32'(core_irq), 32'(eirq));
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_core = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; irq_in = '0;
    m_sw = '0; m_mask = '1; m_lines = '0; m_ipip = '0; m_ipim = '0;
    for (int i = 0; i < N; i++) m_aff[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;

    // R3: reset state
    check("R3", 32'(core_irq), 32'd0);
    for (int c = 0; c < C; c++) begin
      rd(c, 16'h2004, "R3", q); check("R3", q, 32'd0);
    end
    rd(0, 16'h4100, "R3", q); check("R3", q, 32'hFFFF_FFFF);
    rd(0, 16'h4084, "R3", q); check("R3", q, 32'd0);
    rd(0, 16'h3028, "R3", q); check("R3", q, 32'd0);

    // R1, R2
    rd(2, 16'h0004, "R1", q); check("R1", q, 32'd64);
    rd(3, 16'h2000, "R2", q); check("R2", q, 32'd3);

    // R11: upper routing bits dropped
    wr(0, 16'h30FC, 32'hFFFF_FFF2);
    rd(0, 16'h30FC, "R11", q); check("R11", q, 32'h2);

    // lines 5 and 40 routed to core 1, made pending by software
    wr(0, 16'h3014, 32'h2);
    wr(0, 16'h30A0, 32'h2);
    wr(0, 16'h4000, 32'h20);
    wr(0, 16'h4004, 32'h100);
    wr(0, 16'h4180, 32'hFFFF_FFFF);
    wr(0, 16'h4184, 32'hFFFF_FFFF);
    rd(0, 16'h4000, "R4", q); check("R4", q, 32'h20);
    check("R10", 32'(core_irq), 32'h2);
    rd(1, 16'h2004, "R6", q); check("R6", q, 32'h0001_0005);
    rd(1, 16'h2004, "R7", q); check("R7", q, 32'h0001_0028);
    rd(0, 16'h4100, "R7", q); check("R7", q, 32'h20);
    rd(1, 16'h2004, "R12", q); check("R12", q, 32'd0);
    rd(0, 16'h2004, "R6", q); check("R6", q, 32'd0);

    // hardware line at the top boundary
    set_lines(64'h8000_0000_0000_0000);
    rd(1, 16'h2004, "R6", q); check("R6", q, 32'h0001_003F);

    // R8, R9: inter-processor interrupt precedence and masking
    wr(0, 16'h4184, 32'hFFFF_FFFF);
    wr(0, 16'h2008, 32'h2);
    rd(1, 16'h2004, "R8", q); check("R8", q, 32'h0004_0001);
    rd(1, 16'h2004, "R9", q); check("R9", q, 32'h0001_0028);
    rd(1, 16'h2004, "R9", q); check("R9", q, 32'h0001_003F);
    rd(1, 16'h2004, "R9", q); check("R9", q, 32'd0);
    check("R10", 32'(core_irq), 32'd0);
    wr(1, 16'h2028, 32'h1);
    check("R10", 32'(core_irq), 32'h2);
    rd(1, 16'h2004, "R9", q); check("R9", q, 32'h0004_0001);
    wr(1, 16'h2028, 32'h1);
    wr(1, 16'h200C, 32'h1);
    rd(1, 16'h2004, "R9", q); check("R9", q, 32'd0);

    // R4 clear, R5 set
    wr(0, 16'h4080, 32'h20);
    rd(0, 16'h4000, "R4", q); check("R4", q, 32'd0);
    wr(0, 16'h4104, 32'h1);
    rd(0, 16'h4184, "R5", q); check("R5", q, 32'h8000_0101);
    set_lines('0);

    // constrained random phase against the model
    for (int n = 0; n < 3000; n++) begin
      int r, c, ln, w;
      logic [31:0] d;
      r  = int'($urandom % 16);
      c  = int'($urandom % C);
      ln = int'($urandom % N);
      w  = int'($urandom % (N/32));
      d  = $urandom & $urandom;
      case (r)
        0, 1: set_lines({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
        2:    wr(c, 16'h4000 + 16'(w*4), d);
        3:    wr(c, 16'h4080 + 16'(w*4), $urandom);
        4:    wr(c, 16'h4100 + 16'(w*4), d);
        5, 6: wr(c, 16'h4180 + 16'(w*4), $urandom);
        7:    wr(c, 16'h3000 + 16'(ln*4), $urandom);
        8:    wr(c, 16'h2008, $urandom);
        9:    wr(c, 16'h200C, $urandom);
        10:   wr(c, 16'h2028, $urandom);
        11: begin
          case ($urandom % 4)
            0: rd(c, 16'h3000 + 16'(ln*4), "R11", q);
            1: rd(c, 16'h4000 + 16'(w*4) + 16'(($urandom % 2) * 128), "R4", q);
            2: rd(c, 16'h4100 + 16'(w*4) + 16'(($urandom % 2) * 128), "R5", q);
            default: rd(c, 16'h2000, "R2", q);
          endcase
        end
        default: rd(c, 16'h2004, "R6", q);
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule